// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns 48-bit virtual addresses into physical addresses. Pages are 4 KiB, so the low 12 bits of the address pass through unchanged. The 36-bit virtual page number is looked up first in a small fully associative translation buffer. On a hit the answer appears in the cycle after the request is accepted.

On a miss the block walks a radix page table with four levels, starting at the top level. Each level is indexed by 9 bits of the page number. Each table node holds 512 entries of 8 bytes, so a node fills exactly one page. Every entry fetch goes through a single memory read port, and each fetch depends on the entry returned before it.

A successful walk writes its translation into the buffer, replacing the oldest entry. An entry whose present bit is clear ends the walk with a page fault. Only one walk can be in progress, and new requests are held off until it ends. The top-level table's page number comes from a root input that the surrounding system holds steady.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_rd_valid` and `rsp_valid` are 0.
- R2: A successful response carries `rsp_paddr` = {physical page number, `req_vaddr[11:0]`}. The page number comes from bits [39:12] of the leaf entry.
- R3: The entry fetched at walk level L (0 = top level) is read at the byte address (table base × 4096) + 8 × index, where the index is `vaddr[47-9L : 39-9L]`. The table base is `root_ppn` at level 0. At every later level it is bits [39:12] of the entry fetched at the level above.
- R4: On a buffer miss, the levels are fetched in order 0, 1, 2, 3, one read at a time. The next read is issued only after the previous one is acknowledged by `mem_rd_ack`.
- R5: On a buffer hit, `rsp_valid` is 1 with `rsp_fault` = 0 in the cycle after acceptance, and no memory read is issued. The stored translation is returned even if the table in memory has changed since it was stored.
- R6: A fetched entry with bit 0 (present) clear ends the walk at once. The block answers with `rsp_fault` = 1 and `rsp_paddr` = 0. The failed translation is not stored, so a repeat of the request walks again.
- R7: A walk that reaches a present leaf stores its translation in the buffer. When all `TLB_N` (default 4) slots are used, the oldest stored translation is replaced, in first-in, first-out order. At most one slot matches any page.
- R8: `req_ready` is 0 for the whole of a walk, so no request is accepted while a walk is in progress.
- R9: While `mem_rd_valid` is 1 and no acknowledge has arrived, `mem_rd_valid` and `mem_rd_addr` stay unchanged.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| root_ppn | input | 28 | Page number of the top-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 40 | Byte address of the entry |
| mem_rd_ack | input | 1 | Read data valid, ends the read |
| mem_rd_data | input | 64 | Page-table entry read from memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 40 | Translated physical address |

## Verification
The assertions check, on every cycle, that:
- a hit answers in the next cycle and a miss starts a read instead;
- at most one buffer slot matches a page;
- no request is accepted while a read is pending;
- the read address holds until it is acknowledged;
- faults carry a zero address;
- the page offset passes through.

Some behaviour only the bench's scenarios can show. These are the exact entry addresses at each level, and the four-read order against a memory that answers with varying latency. The bench also shows that a stale but stored translation is still returned after the table changes, and that faulting pages are not stored. Finally, it shows first-in, first-out eviction once a fifth page is walked.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PA_W   = 40,
  parameter int TLB_N  = 4,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PG_W   = 12,
  localparam int VA_W  = PG_W + LEVELS * IDX_W,
  localparam int PPN_W = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [63:0]      mem_rd_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int VPN_W  = LEVELS * IDX_W;
  localparam int LV_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int TI_W   = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int ENT_SH = 3;

  logic             walking;
  logic [LV_W-1:0]  lvl;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] base_q;

  logic [TLB_N-1:0] t_val;
  logic [VPN_W-1:0] t_vpn [TLB_N];
  logic [PPN_W-1:0] t_ppn [TLB_N];
  logic [TI_W-1:0]  fill_ptr;

  logic [TLB_N-1:0] hit_vec;
  logic [PPN_W-1:0] hit_ppn;
  logic [IDX_W-1:0] lvl_idx [LEVELS];

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:PG_W];
  wire             accept  = req_valid && req_ready;
  wire             tlb_hit = |hit_vec;

  wire             pte_present = mem_rd_data[0];
  wire [PPN_W-1:0] pte_ppn     = mem_rd_data[PG_W +: PPN_W];
  wire             last_lvl    = (lvl == LV_W'(LEVELS - 1));
  wire             install     = walking && mem_rd_ack && pte_present && last_lvl;
  wire             unused_pte  = ^{mem_rd_data[63:PA_W], mem_rd_data[PG_W-1:1]};

  genvar g;
  generate
    for (g = 0; g < TLB_N; g++) begin : g_cmp
      assign hit_vec[g] = t_val[g] && (t_vpn[g] == req_vpn);
    end
    for (g = 0; g < LEVELS; g++) begin : g_idx
      assign lvl_idx[g] = va_q[PG_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | t_ppn[i];
  end

  assign req_ready    = !walking;
  assign mem_rd_valid = walking;
  assign mem_rd_addr  = {base_q, {PG_W{1'b0}}} | PA_W'({lvl_idx[lvl], {ENT_SH{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      lvl       <= '0;
      va_q      <= '0;
      base_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      t_val     <= '0;
      fill_ptr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        va_q   <= req_vaddr;
        lvl    <= '0;
        base_q <= root_ppn;
        if (tlb_hit) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= {hit_ppn, req_vaddr[PG_W-1:0]};
        end else begin
          walking <= 1'b1;
        end
      end else if (walking && mem_rd_ack) begin
        if (!pte_present) begin
          walking   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          rsp_paddr <= '0;
        end else if (last_lvl) begin
          walking         <= 1'b0;
          rsp_valid       <= 1'b1;
          rsp_fault       <= 1'b0;
          rsp_paddr       <= {pte_ppn, va_q[PG_W-1:0]};
          t_val[fill_ptr] <= 1'b1;
          fill_ptr        <= (fill_ptr == TI_W'(TLB_N - 1)) ? '0 : fill_ptr + TI_W'(1);
        end else begin
          base_q <= pte_ppn;
          lvl    <= lvl + LV_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      t_vpn[fill_ptr] <= va_q[VA_W-1:PG_W];
      t_ppn[fill_ptr] <= pte_ppn;
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W  = 40,
  parameter int TLB_N = 4,
  parameter int PG_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TLB_N-1:0] hit_vec,
  input logic             mem_rd_valid,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_ack,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [PG_W-1:0]  va_off
);
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && |hit_vec) |=> (rsp_valid && !rsp_fault)); // R5
  AST_MISS_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(|hit_vec)) |=> (mem_rd_valid && !rsp_valid)); // R4
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7
  AST_NO_ACCEPT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready); // R8
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R9
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[PG_W-1:0] == va_off)); // R2
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .TLB_N(TLB_N), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .hit_vec(hit_vec), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_rd_ack(mem_rd_ack), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .va_off(va_q[PG_W-1:0])
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_NS = 10;
  localparam int PA_W   = 40;
  localparam int TLB_N  = 4;
  localparam int VA_W   = 48;
  localparam int PPN_W  = 28;
  localparam longint unsigned ROOT = 'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [PPN_W-1:0] root_ppn = PPN_W'(ROOT);
  logic mem_rd_valid, mem_rd_ack = 1'b0;
  logic [PA_W-1:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic rsp_valid, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;

  always #(CLK_NS/2) clk = ~clk;

  ptw_walker #(.PA_W(PA_W), .TLB_N(TLB_N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_ppn(root_ppn), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int errors = 0, checks = 0;
  longint unsigned pmem [longint unsigned];
  longint unsigned next_node = 'h200;
  longint unsigned seen [$];
  longint unsigned exp_addrs [$];
  longint unsigned mt_vpn [$];
  longint unsigned mt_ppn [$];
  bit m_fault;
  longint unsigned m_ppn;

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned ent_addr(longint unsigned base, longint unsigned va, int lv);
    return (base << 12) + (((va >> (12 + 9 * (3 - lv))) & 'h1ff) << 3);
  endfunction

  task automatic map_page(longint unsigned va, longint unsigned ppn);
    longint unsigned base = ROOT;
    for (int lv = 0; lv < 3; lv++) begin
      longint unsigned a = ent_addr(base, va, lv);
      if (!pmem.exists(a)) begin
        pmem[a] = (next_node << 12) | 1;
        next_node++;
      end
      base = pmem[a] >> 12;
    end
    pmem[ent_addr(base, va, 3)] = (ppn << 12) | 1;
  endtask

  task automatic model_walk(longint unsigned va);
    longint unsigned base = ROOT;
    exp_addrs.delete();
    m_fault = 1'b0;
    for (int lv = 0; lv < 4; lv++) begin
      longint unsigned a = ent_addr(base, va, lv);
      longint unsigned e = pmem.exists(a) ? pmem[a] : 0;
      exp_addrs.push_back(a);
      if ((e & 1) == 0) begin
        m_fault = 1'b1;
        return;
      end
      base = e >> 12;
    end
    m_ppn = base;
  endtask

  int wait_cnt = 0, lat_sel = 0;
  bit prev_valid = 1'b0, prev_ack = 1'b0;
  longint unsigned prev_addr = 0;
  always @(negedge clk) begin
    if (rst_n && prev_valid && !prev_ack)
      chk(mem_rd_valid && (longint'(mem_rd_addr) == prev_addr), "R9", "read held until ack",
          longint'(mem_rd_addr), prev_addr);
    mem_rd_ack = 1'b0;
    if (rst_n && mem_rd_valid) begin
      if (wait_cnt >= lat_sel % 3) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = pmem.exists(longint'(mem_rd_addr)) ? pmem[longint'(mem_rd_addr)] : 64'd0;
        seen.push_back(longint'(mem_rd_addr));
        wait_cnt = 0;
        lat_sel++;
      end else begin
        wait_cnt++;
      end
    end
    prev_valid = rst_n && mem_rd_valid;
    prev_ack   = mem_rd_ack;
    prev_addr  = longint'(mem_rd_addr);
  end

  task automatic translate(longint unsigned va);
    bit hit = 1'b0;
    longint unsigned hppn = 0;
    int n0, cyc;
    foreach (mt_vpn[i]) if (mt_vpn[i] == (va >> 12)) begin hit = 1'b1; hppn = mt_ppn[i]; end
    if (!hit) model_walk(va);
    n0 = seen.size();
    chk(req_ready == 1'b1, "R8", "ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va[VA_W-1:0];
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (hit) begin
      chk(rsp_valid == 1'b1, "R5", "hit answers next cycle", rsp_valid, 1);
      chk(rsp_fault == 1'b0, "R5", "hit not a fault", rsp_fault, 0);
      chk(longint'(rsp_paddr) == ((hppn << 12) | (va & 'hfff)), "R2", "hit paddr",
          longint'(rsp_paddr), (hppn << 12) | (va & 'hfff));
      chk(seen.size() == n0, "R5", "no reads on hit", seen.size() - n0, 0);
    end else begin
      cyc = 0;
      while (!rsp_valid && cyc < 100) begin
        chk(req_ready == 1'b0, "R8", "ready low during walk", req_ready, 0);
        @(negedge clk); #1;
        cyc++;
      end
      chk(rsp_valid == 1'b1, "R4", "walk completes", rsp_valid, 1);
      chk(seen.size() - n0 == exp_addrs.size(), "R4", "fetch count", seen.size() - n0, exp_addrs.size());
      foreach (exp_addrs[i])
        if (n0 + i < seen.size())
          chk(seen[n0 + i] == exp_addrs[i], "R3", "entry address", seen[n0 + i], exp_addrs[i]);
      if (m_fault) begin
        chk(rsp_fault == 1'b1, "R6", "fault flag", rsp_fault, 1);
        chk(rsp_paddr == '0, "R6", "fault paddr zero", longint'(rsp_paddr), 0);
      end else begin
        chk(rsp_fault == 1'b0, "R2", "walk not a fault", rsp_fault, 0);
        chk(longint'(rsp_paddr) == ((m_ppn << 12) | (va & 'hfff)), "R2", "walk paddr",
            longint'(rsp_paddr), (m_ppn << 12) | (va & 'hfff));
        mt_vpn.push_back(va >> 12);
        mt_ppn.push_back(m_ppn);
        if (mt_vpn.size() > TLB_N) begin
          void'(mt_vpn.pop_front());
          void'(mt_ppn.pop_front());
        end
      end
    end
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R10", "single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam longint unsigned VA_A = 'h7f12_3456_7abc;
  initial begin
    map_page(VA_A, 'h0abcd);
    for (int k = 1; k <= 4; k++) map_page(VA_A + (k << 12), 'h500 + k);
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(mem_rd_valid == 1'b0, "R1", "no read in reset", mem_rd_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1 && mem_rd_valid == 1'b0 && rsp_valid == 1'b0, "R1", "idle after reset",
        {req_ready, mem_rd_valid, rsp_valid}, 3'b100);

    translate(VA_A);                            // R3 R4 R2: first walk
    translate(VA_A ^ 'h5a5);                    // R5: same page, other offset
    map_page(VA_A, 'h0beef);                    // table changes behind the buffer
    translate(VA_A ^ 'h001);                    // R5: stale stored value returned
    translate('h0001_0000_0040);                // R6: top-level entry absent
    translate('h0001_0000_0040);                // R6: not stored, walks again
    translate(VA_A ^ (64'd1 << 21));            // R6: third-level entry absent
    for (int k = 1; k <= 4; k++) translate(VA_A + (k << 12)); // R7: fill, evict oldest
    translate(VA_A);                            // R7: evicted, walks, new leaf
    translate(VA_A + (4 << 12));                // R7: still stored
    translate(VA_A + (1 << 12));                // R7: evicted by refill
    translate(VA_A + (4 << 12) + 'h10);         // R5 hit

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule